// File: doc/BRIEF.md
# Memory-Write Command Packet Parser

This block sits behind a serial-link receiver. It takes one command packet at a time as a byte stream. Each beat is an 8-bit data byte or an end marker, which is either a normal end-of-packet or an error end. The routing path bytes have already been removed, so the first byte is the target logical address. The parser walks the fixed-order header, skips the reply-address section (its length is variable), and captures the fields a memory agent needs: extended address plus 32-bit address, a 24-bit length, transaction ID, logical addresses, key and the reply-address bytes. It also checks the header CRC.

For a well-formed write command, the parser raises a header strobe. It then streams exactly the announced number of payload bytes over a valid/ready port and checks the trailing data CRC. It ends each packet with a single status pulse that carries a result code and a flag saying whether a reply should be sent. Read and read-modify-write commands are rejected with a code and never stream data. Packets for another protocol are dropped without any report.

Top module: `mwp_cmd_parser`

## Requirements
- R1: A packet whose second byte (protocol identifier) is not 0x01 is discarded up to its end marker: no status pulse, no header strobe and no payload byte.
- R2: When the header CRC byte is accepted with a correct CRC and a write command, `hdr_valid_o` pulses for one cycle. At that point `mem_addr_o` is {extended address, four address bytes MS first}, `len_o` is the three length bytes MS first, and `tid_o` is {ID high, ID low}.
- R3: The instruction byte's bits [1:0] give the reply-address length in 4-byte words (0, 4, 8 or 12 bytes). Those bytes sit between the key and the initiator address. They appear in `reply_addr_o` right-aligned, with the last received byte in bits [7:0] and zeros above the received bytes.
- R4: A header CRC mismatch gives status code 1 with the reply flag low. No payload follows and the rest of the packet is discarded silently.
- R5: A correct header whose instruction bits [6:5] are not 2'b11 (not a write command) gives status code 5. The reply flag equals instruction bit 3. No payload is streamed.
- R6: Exactly `len_o` payload bytes are delivered in order. `pl_last_o` is set only on the final byte. While `pl_valid_o` is high and `pl_ready_i` is low, the data and last flag hold and no further input byte is taken. A zero length streams nothing.
- R7: Both CRCs use x^8+x^2+x+1 with bit-reflected input and zero start value. The header CRC restarts after the header CRC byte. A packet that ends with EOP straight after its data CRC byte reports code 0 if the CRC over data plus CRC byte is zero, and code 2 otherwise. In both cases the reply flag equals instruction bit 3.
- R8: An EOP arriving before the data CRC byte has been taken (after at least one byte) gives code 3. The reply flag is set only if the header CRC had already passed and instruction bit 3 is set.
- R9: A data byte arriving where the end marker is due gives code 4, reported one cycle after that byte. The rest of the packet is discarded silently.
- R10: A packet ending in an error-end marker gives code 6. Its reply flag is instruction bit 3 AND `eep_reply_i` AND a passed header CRC.
- R11: Each packet not covered by R1 yields exactly one single-cycle `stat_valid_o` pulse. For end-decided results, the pulse comes the cycle after the end marker is accepted.
- R12: After reset, `rx_ready_o` is high and `pl_valid_o`, `hdr_valid_o` and `stat_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eep_reply_i | input | 1 | Request a reply for packets ended by an error end |
| rx_valid_i | input | 1 | Input beat valid |
| rx_ready_o | output | 1 | Input beat accepted |
| rx_data_i | input | 8 | Input data byte |
| rx_eop_i | input | 1 | Beat is a normal end-of-packet marker |
| rx_eep_i | input | 1 | Beat is an error end-of-packet marker |
| pl_valid_o | output | 1 | Payload byte valid |
| pl_ready_i | input | 1 | Payload sink ready |
| pl_data_o | output | 8 | Payload byte |
| pl_last_o | output | 1 | Final payload byte |
| hdr_valid_o | output | 1 | Header accepted strobe |
| tgt_la_o | output | 8 | Target logical address |
| instr_o | output | 8 | Instruction byte |
| key_o | output | 8 | Key byte |
| reply_addr_o | output | 96 | Reply-address bytes, right-aligned |
| init_la_o | output | 8 | Initiator logical address |
| tid_o | output | 16 | Transaction ID |
| mem_addr_o | output | 40 | Extended address and address |
| len_o | output | 24 | Payload length |
| stat_valid_o | output | 1 | Packet result strobe |
| stat_code_o | output | 3 | Result code |
| stat_reply_o | output | 1 | A reply should be sent |

## Verification
Every result is one register stage past the edge that accepts the deciding beat. The header strobe comes the cycle after the header CRC byte. A payload byte shows on the output the cycle after its input byte is taken, and the status pulse comes the cycle after the end marker, or after the header CRC byte or the surplus byte for those errors. The bench drives and samples on the falling edge. It counts cycles on that edge, and for each normally ended packet it checks that the status pulse lands on the same falling edge as the one following acceptance of the end marker. Under output backpressure, payload is recorded only when valid and ready are both set for the coming rising edge.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_HDR_CRC   = 3'd1,
    ST_DATA_CRC  = 3'd2,
    ST_EARLY_END = 3'd3,
    ST_TOO_LONG  = 3'd4,
    ST_UNSUP     = 3'd5,
    ST_ERR_END   = 3'd6
  } status_e;

  typedef enum logic [3:0] {
    P_TLA, P_PID, P_INSTR, P_KEY, P_RPLY, P_ILA, P_TID, P_EXT,
    P_ADDR, P_LEN, P_HCRC, P_DATA, P_DCRC, P_END, P_DROP
  } phase_e;

  localparam logic [7:0] PROTO_ID = 8'h01;
endpackage

// File: rtl/mwp_crc8.sv
module mwp_crc8 #(
  parameter logic [7:0] POLY_REFL = 8'hE0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o,
  output logic [7:0] crc_nxt_o
);
  logic [7:0] crc_q;

  always_comb begin
    logic [7:0] c;
    c = crc_q;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data_i[i]) c = (c >> 1) ^ POLY_REFL;
      else                  c = c >> 1;
    end
    crc_nxt_o = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_nxt_o;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/mwp_pl_reg.sv
module mwp_pl_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o,
  output logic         space_o
);
  logic         valid_q, last_q;
  logic [W-1:0] data_q;

  assign space_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
      last_q  <= last_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;
endmodule

// File: rtl/mwp_cmd_parser.sv
module mwp_cmd_parser
  import mwp_pkg::*;
#(
  parameter int ADDR_BYTES     = 4,
  parameter int LEN_BYTES      = 3,
  parameter int RPLY_MAX_WORDS = 3,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int LEN_W  = 8 * LEN_BYTES,
  localparam int RPLY_W = 32 * RPLY_MAX_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eep_reply_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_eop_i,
  input  logic              rx_eep_i,
  output logic              pl_valid_o,
  input  logic              pl_ready_i,
  output logic [7:0]        pl_data_o,
  output logic              pl_last_o,
  output logic              hdr_valid_o,
  output logic [7:0]        tgt_la_o,
  output logic [7:0]        instr_o,
  output logic [7:0]        key_o,
  output logic [RPLY_W-1:0] reply_addr_o,
  output logic [7:0]        init_la_o,
  output logic [15:0]       tid_o,
  output logic [ADDR_W+7:0] mem_addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              stat_valid_o,
  output logic [2:0]        stat_code_o,
  output logic              stat_reply_o
);
  phase_e              state_q;
  logic [LEN_W-1:0]    cnt_q, len_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [RPLY_W-1:0]   reply_q;
  logic [15:0]         tid_q;
  logic [7:0]          tla_q, instr_q, key_q, ila_q, ext_q;
  logic                hdr_pass_q, hdr_valid_q;
  logic                stat_valid_q, stat_reply_q;
  status_e             stat_code_q;

  logic       is_mark, rx_fire, pl_space, pl_load, pl_last;
  logic [7:0] crc_q, crc_nxt;
  logic       end_reply;
  status_e    end_code;
  logic [3:0] rply_last;

  assign is_mark    = rx_eop_i || rx_eep_i;
  assign rx_ready_o = (state_q != P_DATA) || pl_space;
  assign rx_fire    = rx_valid_i && rx_ready_o;
  assign pl_load    = rx_fire && !is_mark && (state_q == P_DATA);
  assign pl_last    = (cnt_q == len_q - LEN_W'(1));
  assign rply_last  = {instr_q[1:0], 2'b00} - 4'd1;

  mwp_crc8 u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rx_fire && (is_mark || state_q == P_HCRC)),
    .en_i     (rx_fire && !is_mark),
    .data_i   (rx_data_i),
    .crc_o    (crc_q),
    .crc_nxt_o(crc_nxt)
  );

  mwp_pl_reg #(.W(8)) u_pl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pl_load),
    .data_i (rx_data_i),
    .last_i (pl_last),
    .ready_i(pl_ready_i),
    .valid_o(pl_valid_o),
    .data_o (pl_data_o),
    .last_o (pl_last_o),
    .space_o(pl_space)
  );

  always_comb begin
    end_reply = hdr_pass_q && instr_q[3] && (!rx_eep_i || eep_reply_i);
    if (rx_eep_i)              end_code = ST_ERR_END;
    else if (state_q != P_END) end_code = ST_EARLY_END;
    else if (crc_q == 8'h00)   end_code = ST_OK;
    else                       end_code = ST_DATA_CRC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= P_TLA;
      cnt_q        <= '0;
      len_q        <= '0;
      addr_q       <= '0;
      reply_q      <= '0;
      tid_q        <= '0;
      tla_q        <= '0;
      instr_q      <= '0;
      key_q        <= '0;
      ila_q        <= '0;
      ext_q        <= '0;
      hdr_pass_q   <= 1'b0;
      hdr_valid_q  <= 1'b0;
      stat_valid_q <= 1'b0;
      stat_reply_q <= 1'b0;
      stat_code_q  <= ST_OK;
    end else begin
      stat_valid_q <= 1'b0;
      hdr_valid_q  <= 1'b0;
      if (rx_fire && is_mark) begin
        state_q    <= P_TLA;
        cnt_q      <= '0;
        hdr_pass_q <= 1'b0;
        if (state_q != P_TLA && state_q != P_DROP) begin
          stat_valid_q <= 1'b1;
          stat_code_q  <= end_code;
          stat_reply_q <= end_reply;
        end
      end else if (rx_fire) begin
        case (state_q)
          P_TLA:   begin tla_q <= rx_data_i; state_q <= P_PID; end
          P_PID:   state_q <= (rx_data_i == PROTO_ID) ? P_INSTR : P_DROP;
          P_INSTR: begin instr_q <= rx_data_i; state_q <= P_KEY; end
          P_KEY: begin
            key_q   <= rx_data_i;
            reply_q <= '0;
            cnt_q   <= '0;
            state_q <= (instr_q[1:0] == 2'd0) ? P_ILA : P_RPLY;
          end
          P_RPLY: begin
            reply_q <= {reply_q[RPLY_W-9:0], rx_data_i};
            if (cnt_q[3:0] == rply_last) begin cnt_q <= '0; state_q <= P_ILA; end
            else cnt_q <= cnt_q + LEN_W'(1);
          end
          P_ILA: begin ila_q <= rx_data_i; cnt_q <= '0; state_q <= P_TID; end
          P_TID: begin
            tid_q <= {tid_q[7:0], rx_data_i};
            if (cnt_q == LEN_W'(1)) begin cnt_q <= '0; state_q <= P_EXT; end
            else cnt_q <= cnt_q + LEN_W'(1);
          end
          P_EXT: begin ext_q <= rx_data_i; state_q <= P_ADDR; end
          P_ADDR: begin
            addr_q <= {addr_q[ADDR_W-9:0], rx_data_i};
            if (cnt_q == LEN_W'(ADDR_BYTES - 1)) begin cnt_q <= '0; state_q <= P_LEN; end
            else cnt_q <= cnt_q + LEN_W'(1);
          end
          P_LEN: begin
            len_q <= {len_q[LEN_W-9:0], rx_data_i};
            if (cnt_q == LEN_W'(LEN_BYTES - 1)) begin cnt_q <= '0; state_q <= P_HCRC; end
            else cnt_q <= cnt_q + LEN_W'(1);
          end
          P_HCRC: begin
            cnt_q <= '0;
            if (crc_nxt != 8'h00) begin
              stat_valid_q <= 1'b1;
              stat_code_q  <= ST_HDR_CRC;
              stat_reply_q <= 1'b0;
              state_q      <= P_DROP;
            end else begin
              hdr_pass_q <= 1'b1;
              if (!(instr_q[6] && instr_q[5])) begin
                stat_valid_q <= 1'b1;
                stat_code_q  <= ST_UNSUP;
                stat_reply_q <= instr_q[3];
                state_q      <= P_DROP;
              end else begin
                hdr_valid_q <= 1'b1;
                state_q     <= (len_q == '0) ? P_DCRC : P_DATA;
              end
            end
          end
          P_DATA: begin
            cnt_q <= cnt_q + LEN_W'(1);
            if (pl_last) state_q <= P_DCRC;
          end
          P_DCRC: state_q <= P_END;
          P_END: begin
            stat_valid_q <= 1'b1;
            stat_code_q  <= ST_TOO_LONG;
            stat_reply_q <= instr_q[3];
            state_q      <= P_DROP;
          end
          default: ;
        endcase
      end
    end
  end

  assign hdr_valid_o  = hdr_valid_q;
  assign tgt_la_o     = tla_q;
  assign instr_o      = instr_q;
  assign key_o        = key_q;
  assign reply_addr_o = reply_q;
  assign init_la_o    = ila_q;
  assign tid_o        = tid_q;
  assign mem_addr_o   = {ext_q, addr_q};
  assign len_o        = len_q;
  assign stat_valid_o = stat_valid_q;
  assign stat_code_o  = stat_code_q;
  assign stat_reply_o = stat_reply_q;
endmodule

// File: rtl/mwp_cmd_parser_chk.sv
module mwp_cmd_parser_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_ready_o,
  input logic       pl_valid_o,
  input logic       pl_ready_i,
  input logic [7:0] pl_data_o,
  input logic       pl_last_o,
  input logic       hdr_valid_o,
  input logic       stat_valid_o,
  input logic [2:0] stat_code_o,
  input logic       stat_reply_o,
  input logic [3:0] state_i
);
  import mwp_pkg::*;

  a_r6_payload_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_valid_o && !pl_ready_i |=> pl_valid_o && $stable(pl_data_o) && $stable(pl_last_o));

  a_r6_stall_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == P_DATA) && pl_valid_o && !pl_ready_i |-> !rx_ready_o);

  a_r6_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_last_o |-> pl_valid_o);

  a_r11_single_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);

  a_r2_single_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o);

  a_r2_hdr_no_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> !stat_valid_o);

  a_r4_hdr_err_no_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o && (stat_code_o == 3'd1) |-> !stat_reply_o);
endmodule

bind mwp_cmd_parser mwp_cmd_parser_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_ready_o  (rx_ready_o),
  .pl_valid_o  (pl_valid_o),
  .pl_ready_i  (pl_ready_i),
  .pl_data_o   (pl_data_o),
  .pl_last_o   (pl_last_o),
  .hdr_valid_o (hdr_valid_o),
  .stat_valid_o(stat_valid_o),
  .stat_code_o (stat_code_o),
  .stat_reply_o(stat_reply_o),
  .state_i     (state_q)
);

// File: tb/mwp_cmd_parser_tb_top.sv
module mwp_cmd_parser_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eep_reply_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic        rx_ready_o;
  logic [7:0]  rx_data_i = 8'h00;
  logic        rx_eop_i = 1'b0;
  logic        rx_eep_i = 1'b0;
  logic        pl_valid_o;
  logic        pl_ready_i = 1'b1;
  logic [7:0]  pl_data_o;
  logic        pl_last_o;
  logic        hdr_valid_o;
  logic [7:0]  tgt_la_o, instr_o, key_o, init_la_o;
  logic [95:0] reply_addr_o;
  logic [15:0] tid_o;
  logic [39:0] mem_addr_o;
  logic [23:0] len_o;
  logic        stat_valid_o;
  logic [2:0]  stat_code_o;
  logic        stat_reply_o;

  always #4 clk_i = ~clk_i;

  mwp_cmd_parser dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_stat = 0, n_hdr = 0, stat_cyc = 0, mark_cyc = 0;
  bit bp_mode = 1'b0;
  logic [2:0]  s_code;
  logic        s_reply;
  logic [95:0] h_reply;
  logic [39:0] h_addr;
  logic [23:0] h_len;
  logic [15:0] h_tid;
  logic [7:0]  h_ila;
  logic [7:0]  pkt[$];
  logic [7:0]  exp_pl[$];
  logic [7:0]  got_pl[$];
  logic        got_last[$];

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_upd(logic [7:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'hE0;
      else             c = c >> 1;
    end
    return c;
  endfunction

  always @(negedge clk_i) begin
    cyc++;
    pl_ready_i = bp_mode ? cyc[0] : 1'b1;
    if (pl_valid_o && pl_ready_i) begin
      got_pl.push_back(pl_data_o);
      got_last.push_back(pl_last_o);
    end
    if (stat_valid_o) begin
      n_stat++; stat_cyc = cyc; s_code = stat_code_o; s_reply = stat_reply_o;
    end
    if (hdr_valid_o) begin
      n_hdr++; h_reply = reply_addr_o; h_addr = mem_addr_o; h_len = len_o;
      h_tid = tid_o; h_ila = init_la_o;
    end
  end

  task automatic mk_pkt(logic [7:0] pid, logic [7:0] instr, int len,
                        bit bad_h, bit bad_d, int extra);
    logic [7:0] c = 8'h00;
    logic [7:0] hb[$];
    pkt.delete(); exp_pl.delete();
    hb = {8'hFE, pid, instr, 8'h5A};
    for (int i = 0; i < 4 * instr[1:0]; i++) hb.push_back(8'hA0 + 8'(i));
    hb = {hb, 8'h67, 8'h12, 8'h34, 8'h9A, 8'h01, 8'h23, 8'h45, 8'(len),
          8'(len >> 16), 8'(len >> 8), 8'(len)};
    foreach (hb[i]) begin pkt.push_back(hb[i]); c = crc_upd(c, hb[i]); end
    pkt.push_back(c ^ (bad_h ? 8'h3C : 8'h00));
    c = 8'h00;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'(i * 37 + len + 3);
      pkt.push_back(b); exp_pl.push_back(b); c = crc_upd(c, b);
    end
    pkt.push_back(c ^ (bad_d ? 8'h81 : 8'h00));
    for (int i = 0; i < extra; i++) pkt.push_back(8'hEE);
  endtask

  task automatic send_beat(logic [7:0] d, bit eop, bit eep);
    bit acc;
    rx_valid_i = 1'b1; rx_data_i = d; rx_eop_i = eop; rx_eep_i = eep;
    forever begin
      #2 acc = rx_ready_o;
      @(negedge clk_i);
      if (acc) break;
    end
  endtask

  task automatic send_pkt(int keep, bit eep);
    int n = (keep < 0) ? pkt.size() : keep;
    got_pl.delete(); got_last.delete();
    for (int i = 0; i < n; i++) send_beat(pkt[i], 1'b0, 1'b0);
    send_beat(8'h00, !eep, eep);
    #1 mark_cyc = cyc;
    rx_valid_i = 1'b0; rx_eop_i = 1'b0; rx_eep_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R12", "rx_ready", rx_ready_o, 1);
    chk("R12", "pl_valid", pl_valid_o, 0);
    chk("R12", "hdr_valid", hdr_valid_o, 0);
    chk("R12", "stat_valid", stat_valid_o, 0);
  endtask

  task automatic t_good(logic [7:0] instr, int len, bit bp);
    int s0 = n_stat, h0 = n_hdr;
    logic [95:0] er = '0;
    bp_mode = bp;
    mk_pkt(8'h01, instr, len, 0, 0, 0);
    send_pkt(-1, 0);
    bp_mode = 0;
    for (int i = 0; i < 4 * instr[1:0]; i++) er = {er[87:0], 8'hA0 + 8'(i)};
    chk("R2", "hdr strobes", n_hdr - h0, 1);
    chk("R2", "mem_addr", h_addr, 40'h9A_0123_4500 | 40'(len & 8'hFF));
    chk("R2", "len", h_len, len);
    chk("R2", "tid", h_tid, 16'h1234);
    chk("R2", "init_la", h_ila, 8'h67);
    chk("R3", "reply_addr", h_reply, er);
    chk("R6", "payload count", got_pl.size(), len);
    foreach (got_pl[i]) begin
      if (i < exp_pl.size()) chk("R6", "payload byte", got_pl[i], exp_pl[i]);
      chk("R6", "last flag", got_last[i], i == len - 1);
    end
    chk("R11", "stat count", n_stat - s0, 1);
    chk("R11", "stat timing", stat_cyc, mark_cyc);
    chk("R7", "ok code", s_code, 0);
    chk("R7", "reply flag", s_reply, instr[3]);
  endtask

  task automatic t_pid();
    int s0 = n_stat, h0 = n_hdr;
    mk_pkt(8'h02, 8'h6C, 3, 0, 0, 0);
    send_pkt(-1, 0);
    chk("R1", "no stat", n_stat - s0, 0);
    chk("R1", "no hdr", n_hdr - h0, 0);
    chk("R1", "no payload", got_pl.size(), 0);
  endtask

  task automatic t_err(string req, logic [7:0] instr, int len, bit bad_h, bit bad_d,
                       int extra, int keep, bit eep, logic [2:0] code, bit reply, int npl);
    int s0 = n_stat;
    mk_pkt(8'h01, instr, len, bad_h, bad_d, extra);
    send_pkt(keep, eep);
    chk(req, "stat count", n_stat - s0, 1);
    chk(req, "code", s_code, code);
    chk(req, "reply flag", s_reply, reply);
    chk(req, "payload count", got_pl.size(), npl);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_good(8'h6C, 4, 0);
    t_good(8'h6E, 5, 1);
    t_good(8'h6B, 0, 0);
    t_good(8'h65, 1, 1);
    t_pid();
    t_good(8'h6D, 2, 0);
    t_err("R4", 8'h6C, 4, 1, 0, 0, -1, 0, 3'd1, 0, 0);
    t_err("R5", 8'h4C, 4, 0, 0, 0, -1, 0, 3'd5, 1, 0);
    t_err("R5", 8'h24, 2, 0, 0, 0, -1, 0, 3'd5, 0, 0);
    t_err("R7", 8'h6C, 3, 0, 1, 0, -1, 0, 3'd2, 1, 3);
    t_err("R8", 8'h6C, 6, 0, 0, 0, 6, 0, 3'd3, 0, 0);
    t_err("R8", 8'h6C, 6, 0, 0, 0, 19, 0, 3'd3, 1, 3);
    t_err("R9", 8'h6C, 3, 0, 0, 2, -1, 0, 3'd4, 1, 3);
    eep_reply_i = 1'b1;
    t_err("R10", 8'h6C, 2, 0, 0, 0, -1, 1, 3'd6, 1, 2);
    eep_reply_i = 1'b0;
    t_err("R10", 8'h6C, 2, 0, 0, 0, -1, 1, 3'd6, 0, 2);
    t_good(8'h6C, 7, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule